// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block models the device side of a small flash array while an embedded program or erase runs. A request carries an operation type, a word address and a data word. While the operation is in progress, a read that hits the operation's target returns a status byte instead of array contents. A host can poll that byte to learn whether the operation is still running, has finished, or has failed.

Programming can only clear bits. The stored word becomes the bitwise AND of the old word and the request data. Each cleared bit adds time to the operation. An erase sets every word of one sector back to all ones. An internal cycle counter bounds every operation. If the operation would run past the limit, or if a program request asks to raise a cleared bit, the block enters an error state. It leaves that state only on an explicit clear input.

Reads are byte-addressed over 16-bit words. The word index is `rd_addr[AW:1]`. Status appears only at even byte addresses and only in the low byte.

Top module: `flash_status_resp`

## Requirements
- R1: After reset every word reads 0xFFFF and `busy` is low.
- R2: While a program operation runs, a read at the even byte address of its target word returns 0x00 in bits 15:8. Bit 7 is the inverse of bit 7 of the request data, bit 5 is the error flag, and all other bits are 0.
- R3: A program that raises no bit leaves `busy` high for PROG_CYCLES × max(1, number of bits cleared) cycles after the accepting edge. After that the target word equals old AND data, and reads return array data.
- R4: A program whose data has a 1 where the stored word has a 0 is an error from the accepting edge onward. Status bit 5 is 1 at the first observation, and the array is unchanged.
- R5: An operation whose duration exceeds TIMEOUT_CYCLES stays busy for exactly TIMEOUT_CYCLES cycles and then reports bit 5 = 1, with the array unchanged. A duration equal to the limit completes normally.
- R6: An erase keeps `busy` high for ERASE_CYCLES cycles. During that time a read at any even address of its sector returns status with bit 7 = 0. Afterwards every word of that sector (word index >> log2(SECT_WORDS) equal) is 0xFFFF, and other sectors are untouched.
- R7: In the error state `busy` and status bit 5 stay high until `clear_err` is sampled high. The block is idle on the following cycle.
- R8: A request presented while an operation runs or while in the error state is ignored, including one in the same cycle as `clear_err`.
- R9: During an operation, a read at an odd byte address, or at an address outside the target, returns the array word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request strobe |
| req_erase | input | 1 | 1 = sector erase, 0 = program |
| req_addr | input | AW | Target word index |
| req_data | input | DW | Data to program |
| clear_err | input | 1 | Leaves the error state |
| rd_addr | input | AW+1 | Byte read address |
| rd_data | output | DW | Array word or status |
| busy | output | 1 | Operation running or error held |

## Verification
Leaving the error state and the arrival of a new request can fall on the same edge. The bench provokes this by raising `clear_err` and `req_valid` together, with an all-zero program request to another word. It then judges the result at the ports: `busy` must be low one cycle later, and a full array sweep must show that word unchanged. A second overlap, a request issued while an operation is running, is driven inside the polling loop and judged the same way by the sweep.

// File: rtl/flash_status_resp.sv
module flash_status_resp #(
  parameter int DW             = 16,
  parameter int AW             = 4,
  parameter int SECT_WORDS     = 4,
  parameter int PROG_CYCLES    = 3,
  parameter int ERASE_CYCLES   = 12,
  parameter int TIMEOUT_CYCLES = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_erase,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          clear_err,
  input  logic [AW:0]   rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int WORDS = 1 << AW;
  localparam int SB    = $clog2(SECT_WORDS);
  localparam int CW    = $clog2(PROG_CYCLES * DW + ERASE_CYCLES + TIMEOUT_CYCLES + 2);
  localparam int NW    = $clog2(DW + 1);

  typedef enum logic [1:0] {IDLE_S = 2'd0, BUSY_S = 2'd1, ERR_S = 2'd2} st_t;

  st_t           st_q;
  logic [DW-1:0] mem_q [WORDS];
  logic          op_erase_q;
  logic [AW-1:0] op_addr_q;
  logic [DW-1:0] op_data_q;
  logic [CW-1:0] dur_q, cyc_q;

  wire [DW-1:0] cur  = mem_q[req_addr];
  wire          viol = |(req_data & ~cur);
  wire [NW-1:0] nclr = NW'($countones(cur & ~req_data));
  wire [CW-1:0] pdur = CW'(PROG_CYCLES) * ((nclr == '0) ? CW'(1) : CW'(nclr));
  wire [CW-1:0] ndur = req_erase ? CW'(ERASE_CYCLES) : pdur;
  wire [CW-1:0] cyc1 = cyc_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= IDLE_S;
      op_erase_q <= 1'b0;
      op_addr_q  <= '0;
      op_data_q  <= '0;
      dur_q      <= '0;
      cyc_q      <= '0;
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '1;
    end else begin
      case (st_q)
        IDLE_S: if (req_valid) begin
          op_erase_q <= req_erase;
          op_addr_q  <= req_addr;
          op_data_q  <= req_data;
          dur_q      <= ndur;
          cyc_q      <= '0;
          st_q       <= (!req_erase && viol) ? ERR_S : BUSY_S;
        end
        BUSY_S: begin
          if (cyc1 == dur_q) begin
            st_q <= IDLE_S;
            if (op_erase_q) begin
              for (int w = 0; w < WORDS; w++)
                if ((AW'(w) >> SB) == (op_addr_q >> SB)) mem_q[w] <= '1;
            end else begin
              mem_q[op_addr_q] <= mem_q[op_addr_q] & op_data_q;
            end
          end else if (cyc1 == CW'(TIMEOUT_CYCLES)) begin
            st_q <= ERR_S;
          end else begin
            cyc_q <= cyc1;
          end
        end
        default: if (clear_err) st_q <= IDLE_S;
      endcase
    end
  end

  wire [AW-1:0] rd_word = rd_addr[AW:1];
  wire hit = op_erase_q ? ((rd_word >> SB) == (op_addr_q >> SB)) : (rd_word == op_addr_q);
  wire [7:0] status = {~op_erase_q & ~op_data_q[7], 1'b0, st_q == ERR_S, 5'b0};

  assign busy    = st_q != IDLE_S;
  assign rd_data = (busy && hit && !rd_addr[0]) ? {{(DW-8){1'b0}}, status} : mem_q[rd_word];
endmodule

module flash_status_resp_chk #(
  parameter int AW             = 4,
  parameter int DW             = 16,
  parameter int CW             = 8,
  parameter int TIMEOUT_CYCLES = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          clear_err,
  input logic          busy,
  input logic [1:0]    st,
  input logic [CW-1:0] cyc,
  input logic          op_erase,
  input logic [AW-1:0] op_addr,
  input logic [DW-1:0] op_data
);
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !clear_err) |=> (st == 2'd2 && busy));
  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && clear_err) |=> !busy);
  // R8
  op_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |=> ($stable(op_addr) && $stable(op_data) && $stable(op_erase)));
  // R5
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (cyc < CW'(TIMEOUT_CYCLES)));
  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

bind flash_status_resp flash_status_resp_chk #(
  .AW(AW), .DW(DW), .CW(CW), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .clear_err(clear_err),
  .busy(busy), .st(st_q), .cyc(cyc_q), .op_erase(op_erase_q),
  .op_addr(op_addr_q), .op_data(op_data_q)
);

// File: tb/flash_status_resp_tb.sv
module flash_status_resp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, AW = 4, SECT = 4, PC = 3, EC = 12, TO = 24;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_erase = 1'b0, clear_err = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [AW:0]   rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          busy;

  int compared = 0, mismatched = 0;
  logic [DW-1:0] ref_mem [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_resp #(.DW(DW), .AW(AW), .SECT_WORDS(SECT), .PROG_CYCLES(PC),
    .ERASE_CYCLES(EC), .TIMEOUT_CYCLES(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .clear_err(clear_err),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic int op_dur(input bit er, input logic [DW-1:0] old, input logic [DW-1:0] d);
    int n;
    if (er) return EC;
    n = $countones(old & ~d);
    return PC * ((n == 0) ? 1 : n);
  endfunction

  function automatic logic [DW-1:0] stat_word(input bit er, input logic [DW-1:0] d, input bit e);
    return {8'h00, ~er & ~d[7], 1'b0, e, 5'b0};
  endfunction

  task automatic sweep(input string rq);
    for (int w = 0; w < WORDS; w++) begin
      rd_addr = {AW'(w), 1'b0};
      #1;
      chk(rd_data === ref_mem[w], rq, rd_data, ref_mem[w]);
    end
  endtask

  task automatic run_op(input bit er, input int addr, input logic [DW-1:0] d,
                        input bit poke, input bit clr_req);
    bit v, exp_err;
    int dur, exp_n, n;
    int paddr;
    logic [DW-1:0] old;
    old = ref_mem[addr];
    v   = !er && |(d & ~old);
    dur = op_dur(er, old, d);
    if (v) begin exp_err = 1; exp_n = 0; end
    else if (dur <= TO) begin exp_err = 0; exp_n = dur; end
    else begin exp_err = 1; exp_n = TO; end
    paddr = er ? ((addr / SECT) * SECT + int'($urandom % SECT)) : addr;
    @(negedge clk);
    req_valid = 1; req_erase = er; req_addr = AW'(addr); req_data = d;
    rd_addr = {AW'(paddr), 1'b0};
    @(negedge clk);
    req_valid = 0;
    // R2 R4 R6 first status observation
    chk(busy === 1'b1 && rd_data === stat_word(er, d, v), er ? "R6" : (v ? "R4" : "R2"),
        rd_data, stat_word(er, d, v));
    // R9 odd byte address returns array word
    rd_addr = {AW'(paddr), 1'b1};
    #1;
    chk(rd_data === ref_mem[paddr], "R9", rd_data, ref_mem[paddr]);
    rd_addr = {AW'((paddr + SECT) % WORDS), 1'b0};
    #1;
    chk(rd_data === ref_mem[(paddr + SECT) % WORDS], "R9", rd_data, ref_mem[(paddr + SECT) % WORDS]);
    rd_addr = {AW'(paddr), 1'b0};
    #1;
    n = 0;
    while (busy && !rd_data[5] && n < 200) begin
      n++;
      if (poke && n == 1) begin
        req_valid = 1; req_erase = 1; req_addr = AW'((addr + SECT) % WORDS); req_data = '0;
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    // R3 R5 R6 duration
    chk(n == exp_n, er ? "R6" : (exp_err ? "R5" : "R3"), n, exp_n);
    chk((busy && rd_data[5]) == exp_err, exp_err ? "R5" : "R3", busy, exp_err);
    if (exp_err) begin
      repeat (3) @(negedge clk);
      // R7 error held
      chk(busy === 1'b1 && rd_data === stat_word(er, d, 1'b1), "R7", rd_data, stat_word(er, d, 1'b1));
      clear_err = 1;
      if (clr_req) begin
        req_valid = 1; req_erase = 0; req_addr = AW'((addr + 1) % WORDS); req_data = '0;
      end
      @(negedge clk);
      clear_err = 0; req_valid = 0;
      chk(busy === 1'b0, "R7", busy, 0);
      @(negedge clk);
      // R8 request alongside clear is dropped
      chk(busy === 1'b0, "R8", busy, 0);
    end else if (er) begin
      for (int w = 0; w < WORDS; w++) if (w / SECT == addr / SECT) ref_mem[w] = '1;
    end else begin
      ref_mem[addr] = old & d;
    end
    sweep(er ? "R6" : "R8");
  endtask

  bit wd_hit = 0;
  initial begin
    int cyc = 0;
    while (cyc < 150000 && !wd_hit) begin @(posedge clk); cyc++; end
    if (!wd_hit) begin
      mismatched++; compared++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int r, a;
    logic [DW-1:0] d;
    void'($urandom(32'd1234));
    for (int w = 0; w < WORDS; w++) ref_mem[w] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1", busy, 0);
    sweep("R1");
    run_op(0, 2, 16'hFFFF, 0, 0);   // R3 nothing cleared: minimum duration
    run_op(0, 3, 16'hFF00, 1, 0);   // R5 exactly at limit completes, R8 poke
    run_op(0, 5, 16'h7F00, 0, 0);   // R5 nine bits cleared: time-out
    run_op(0, 3, 16'hFFFF, 0, 1);   // R4 raise cleared bits, R8 clear+request
    run_op(1, 3, 16'h0000, 1, 0);   // R6 erase sector 0
    run_op(0, 9, 16'hFF7F, 0, 0);   // R2 bit 7 cleared, status bit7 = 1
    for (int i = 0; i < 40; i++) begin
      r = int'($urandom % 10);
      a = int'($urandom % WORDS);
      if (r < 2)       run_op(1, a, '0, i % 3 == 0, 0);
      else if (r == 2) run_op(0, a, ~ref_mem[a] | DW'(1 << ($urandom % DW)), 0, i % 2 == 0);
      else begin
        d = ref_mem[a] & DW'($urandom | $urandom | $urandom);
        run_op(0, a, d, i % 4 == 0, 0);
      end
    end
    wd_hit = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule